// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block watches three processor streams: the instruction-fetch address, the load/store address and the load/store data value. Eight comparators each hold a reference value and a two-bit condition. Four of them look at fetch addresses, two at data-access addresses and two at data values. Their results are combined into six watchpoint outputs, registered one cycle after the bus cycle that caused them.

Two event counters can each be attached to any one watchpoint. A counter counts down on each occurrence of that watchpoint and raises the breakpoint request for a single cycle when it reaches zero. It then stays idle until software reloads it.

All settings are written through a simple write-only register port.

Register addresses on `cfg_addr`:

| Address | Contents |
|---|---|
| 0–3 | Reference values of the fetch comparators |
| 4–5 | Reference values of the data-address comparators |
| 6–7 | Reference values of the data-value comparators |
| 8 | Condition codes, two bits per comparator k at bits [2k+1:2k] |
| 9 | Per-watchpoint data-value enable bits, bit j for load/store watchpoint j |
| 10, 11 | Counter 0 and counter 1 |
| 12–15 | Unused |

A counter word carries the occurrence count in bits [15:0] and the watchpoint select in bits [18:16].

Top module: `dbg_watch_unit`

## Requirements
- R1: After a synchronous active-low reset, `wp_out` and `brk_req` are 0. All reference values are 0, all conditions are equal, data-value enables are 0 and both counters are disarmed. As a result, a valid fetch to address 0 together with a valid data access at address 0 with data 0 gives `wp_out` = 6'b111111 and no breakpoint.
- R2: `wp_out[k]` for k in 0..3 is high in the cycle after a valid fetch whose address satisfies comparator k.
- R3: Condition codes are 00 equal, 01 not equal, 10 bus value greater than reference, and 11 bus value less than reference. All comparisons are unsigned.
- R4: `wp_out[4+j]` for j in 0..1 is high in the cycle after a valid data access that meets two conditions. First, its address satisfies comparator 4+j. Second, when data-value enable bit j is set, its data also satisfies comparator 6+j.
- R5: With the corresponding valid strobe low, no watchpoint is raised, whatever the bus values are.
- R6: A counter loaded with count N and select s (0..5) raises `brk_req` for exactly one cycle. That cycle is the one after the N-th cycle in which `wp_out[s]` is high. Select values 6 and 7 never count.
- R7: After firing, a counter ignores further events until it is reloaded. A loaded count of 0 leaves it disarmed.
- R8: Writes to addresses 12–15 change no state.
- R9: `brk_req` is the OR of both counters, so counter 1 can fire independently of counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| if_valid | input | 1 | Fetch address valid |
| if_addr | input | 32 | Fetch effective address |
| da_valid | input | 1 | Data access valid |
| da_addr | input | 32 | Data-access effective address |
| da_data | input | 32 | Data value on the bus |
| wp_out | output | 6 | Watchpoints: [3:0] fetch, [5:4] load/store |
| brk_req | output | 1 | One-cycle breakpoint request |

## Verification
The assertions check on every cycle the following properties:
- No watchpoint appears without its valid strobe in the previous cycle.
- A load/store watchpoint always has its address comparator behind it.
- An equal-condition fetch hit implies exact address equality.
- A counter fires only from a count of one, never for two cycles in a row, and holds zero until reloaded.

Only the bench scenarios can show the following:
- The numeric meaning of each condition code at its boundaries.
- That the data-value enable gates the match.
- That the breakpoint lands after exactly the N-th event.
- That writes to unused addresses leave the settings untouched.

// File: rtl/dbgw_pkg.sv
// Package dbgw_pkg
// Shared types and structural counts for the debug watchpoint unit.
// Assumes the fixed split of comparators: fetch, then data address,
// then data value.
package dbgw_pkg;

    typedef enum logic [1:0] {
        CND_EQ = 2'b00,
        CND_NE = 2'b01,
        CND_GT = 2'b10,
        CND_LT = 2'b11
    } cond_e;

    localparam int unsigned NUM_IWP  = 4;
    localparam int unsigned NUM_LSWP = 2;
    localparam int unsigned NUM_WP   = NUM_IWP + NUM_LSWP;
    localparam int unsigned NUM_CMP  = NUM_IWP + 2 * NUM_LSWP;
    localparam int unsigned NUM_CNT  = 2;
    localparam int unsigned SEL_W    = 3;

endpackage

// File: rtl/dbgw_cmp.sv
// Module dbgw_cmp
// One comparator. It compares a bus value against a reference under a
// two-bit condition and reports a hit only when the bus strobe is valid.
// Assumes unsigned operands of equal width.
module dbgw_cmp
    import dbgw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         valid,
    input  logic [W-1:0] bus_val,
    input  logic [W-1:0] ref_val,
    input  cond_e        cond,
    output logic         hit
);

    logic raw;

    // Evaluate the selected condition on the unqualified operands.
    always_comb begin
        unique case (cond)
            CND_EQ:  raw = (bus_val == ref_val);
            CND_NE:  raw = (bus_val != ref_val);
            CND_GT:  raw = (bus_val >  ref_val);
            default: raw = (bus_val <  ref_val);
        endcase
    end

    // Qualify with the bus strobe so idle cycles never match.
    always_comb hit = valid & raw;

endmodule

// File: rtl/dbgw_evcnt.sv
// Module dbgw_evcnt
// One breakpoint event counter. It is loaded with a count and a
// watchpoint select. It decrements on each selected watchpoint and pulses
// fire for one cycle on reaching zero, then stays idle until reloaded.
// Select values of NWP and above never count.
module dbgw_evcnt #(
    parameter int CW  = 16,
    parameter int NWP = 6,
    parameter int SW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CW-1:0]  load_cnt,
    input  logic [SW-1:0]  load_sel,
    input  logic [NWP-1:0] wp,
    output logic           fire
);

    logic [CW-1:0] cnt;
    logic [SW-1:0] sel;
    logic          ev;

    // Pick the selected watchpoint; out-of-range selects give no event.
    always_comb begin
        ev = 1'b0;
        for (int i = 0; i < NWP; i++) begin
            if (sel == SW'(i)) ev = wp[i];
        end
    end

    // Load, count down on events, and flag the step that reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sel  <= '0;
            fire <= 1'b0;
        end else if (load) begin
            cnt  <= load_cnt;
            sel  <= load_sel;
            fire <= 1'b0;
        end else if (ev && cnt != '0) begin
            cnt  <= cnt - 1'b1;
            fire <= (cnt == CW'(1));
        end else begin
            fire <= 1'b0;
        end
    end

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);                                            // R6
    AST_FIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> $past(cnt) == CW'(1));                      // R6
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> cnt == '0);                        // R7

endmodule

// File: rtl/dbg_watch_unit.sv
// Module dbg_watch_unit
// Top of the debug watchpoint unit. It holds the software-written
// settings, instantiates the eight comparators, and forms the six
// registered watchpoints. It also holds the two event counters that
// drive the breakpoint request.
// Assumes W >= CW + SEL_W so a counter word fits in one register write.
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int W      = 32,
    parameter int CW     = 16,
    parameter int CFG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_wdata,
    input  logic              if_valid,
    input  logic [W-1:0]      if_addr,
    input  logic              da_valid,
    input  logic [W-1:0]      da_addr,
    input  logic [W-1:0]      da_data,
    output logic [NUM_WP-1:0] wp_out,
    output logic              brk_req
);

    localparam int A_COND = NUM_CMP;
    localparam int A_DVEN = NUM_CMP + 1;
    localparam int A_CNT0 = NUM_CMP + 2;
    localparam int CND_W  = 2 * NUM_CMP;

    logic [W-1:0]        cmp_val [NUM_CMP];
    logic [CND_W-1:0]    cond_bits;
    logic [NUM_LSWP-1:0] dv_en;
    logic [NUM_CMP-1:0]  cmp_hit;
    logic [NUM_LSWP-1:0] ls_hit;
    logic [NUM_CNT-1:0]  fire;

    // Register write port for reference values, conditions and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CMP; k++) cmp_val[k] <= '0;
            cond_bits <= '0;
            dv_en     <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (cfg_addr == CFG_AW'(k)) cmp_val[k] <= cfg_wdata;
            end
            if (cfg_addr == CFG_AW'(A_COND)) cond_bits <= cfg_wdata[CND_W-1:0];
            if (cfg_addr == CFG_AW'(A_DVEN)) dv_en     <= cfg_wdata[NUM_LSWP-1:0];
        end
    end

    // Comparator bank: operand source chosen by comparator position.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        logic         v;
        logic [W-1:0] b;
        if (k < NUM_IWP) begin : g_fetch
            always_comb begin
                v = if_valid;
                b = if_addr;
            end
        end else if (k < NUM_IWP + NUM_LSWP) begin : g_daddr
            always_comb begin
                v = da_valid;
                b = da_addr;
            end
        end else begin : g_dval
            always_comb begin
                v = da_valid;
                b = da_data;
            end
        end
        dbgw_cmp #(.W(W)) i_cmp (
            .valid   (v),
            .bus_val (b),
            .ref_val (cmp_val[k]),
            .cond    (cond_e'(cond_bits[2*k +: 2])),
            .hit     (cmp_hit[k])
        );
    end

    // Load/store watchpoints: address match, optionally ANDed with data.
    for (genvar j = 0; j < NUM_LSWP; j++) begin : g_ls
        always_comb ls_hit[j] = cmp_hit[NUM_IWP + j] &
                                (~dv_en[j] | cmp_hit[NUM_IWP + NUM_LSWP + j]);
    end

    // Register the six watchpoint outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_out <= '0;
        else        wp_out <= {ls_hit, cmp_hit[NUM_IWP-1:0]};
    end

    // Event counters, each loaded from its own register address.
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        dbgw_evcnt #(.CW(CW), .NWP(NUM_WP), .SW(SEL_W)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_we && cfg_addr == CFG_AW'(A_CNT0 + c)),
            .load_cnt (cfg_wdata[CW-1:0]),
            .load_sel (cfg_wdata[CW +: SEL_W]),
            .wp       (wp_out),
            .fire     (fire[c])
        );
    end

    // Any counter reaching zero requests a breakpoint.
    always_comb brk_req = |fire;

    AST_IWP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_out[NUM_IWP-1:0]) |-> $past(if_valid));                // R5
    AST_LSWP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_out[NUM_WP-1:NUM_IWP]) |-> $past(da_valid));           // R5
    AST_LS_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wp_out[NUM_IWP] |-> $past(cmp_hit[NUM_IWP]));               // R4
    AST_EQ_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_out[0] && $past(cond_bits[1:0]) == 2'b00)
            |-> $past(if_addr) == $past(cmp_val[0]));               // R3

endmodule

// File: tb/test_dbg_watch_unit.sv
module test_dbg_watch_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        iv;
        logic [31:0] ia;
        logic        dv;
        logic [31:0] da;
        logic [31:0] dd;
        logic [5:0]  exp;
    } vec_t;

    // Comparator setup used by the table:
    // c0 == 0x100, c1 != 0x200, c2 > 0x300, c3 < 0x400,
    // c4 == 0x1000, c5 > 0x2000, c6 == 0xAA, c7 != 0x55,
    // with the data-value enable set for load/store watchpoint 0 only.
    localparam vec_t VEC [11] = '{
        '{1'b1, 32'h100,  1'b0, 32'h0,    32'h0,  6'b001011},
        '{1'b1, 32'h200,  1'b0, 32'h0,    32'h0,  6'b001000},
        '{1'b1, 32'h300,  1'b0, 32'h0,    32'h0,  6'b001010},
        '{1'b1, 32'h400,  1'b0, 32'h0,    32'h0,  6'b000110},
        '{1'b0, 32'h100,  1'b0, 32'h0,    32'h0,  6'b000000},
        '{1'b0, 32'h0,    1'b1, 32'h1000, 32'hAA, 6'b010000},
        '{1'b0, 32'h0,    1'b1, 32'h1000, 32'hAB, 6'b000000},
        '{1'b0, 32'h0,    1'b1, 32'h3000, 32'h55, 6'b100000},
        '{1'b0, 32'h0,    1'b1, 32'h2000, 32'h0,  6'b000000},
        '{1'b0, 32'h0,    1'b0, 32'h1000, 32'hAA, 6'b000000},
        '{1'b1, 32'h100,  1'b1, 32'h1000, 32'hAA, 6'b011011}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        if_valid = 1'b0;
    logic [31:0] if_addr = '0;
    logic        da_valid = 1'b0;
    logic [31:0] da_addr = '0;
    logic [31:0] da_data = '0;
    logic [5:0]  wp_out;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_watch_unit i_dbg_watch_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .if_valid(if_valid), .if_addr(if_addr),
        .da_valid(da_valid), .da_addr(da_addr), .da_data(da_data),
        .wp_out(wp_out), .brk_req(brk_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one bus cycle, sample wp_out, then go idle and sample brk_req.
    task automatic bus(input logic iv, input logic [31:0] ia, input logic dv,
                       input logic [31:0] da, input logic [31:0] dd,
                       output logic [5:0] wp, output logic brk);
        if_valid = iv; if_addr = ia; da_valid = dv; da_addr = da; da_data = dd;
        @(negedge clk);
        wp = wp_out;
        if_valid = 1'b0; da_valid = 1'b0;
        @(negedge clk);
        brk = brk_req;
    endtask

    initial begin
        logic [5:0] wp;
        logic       brk;
        repeat (3) @(negedge clk);
        chk("R1 wp after reset", 32'(wp_out), 32'h0);
        chk("R1 brk after reset", 32'(brk_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus(1'b1, 32'h0, 1'b1, 32'h0, 32'h0, wp, brk);
        chk("R1 reset settings match zero", 32'(wp), 32'h3F);
        chk("R1 counters disarmed", 32'(brk), 32'h0);

        cfg_write(4'd0, 32'h100);  cfg_write(4'd1, 32'h200);
        cfg_write(4'd2, 32'h300);  cfg_write(4'd3, 32'h400);
        cfg_write(4'd4, 32'h1000); cfg_write(4'd5, 32'h2000);
        cfg_write(4'd6, 32'hAA);   cfg_write(4'd7, 32'h55);
        cfg_write(4'd8, 32'h48E4);
        cfg_write(4'd9, 32'h1);
        @(negedge clk);

        // Table walk: R2, R3 (conditions), R4 (load/store), R5 (strobes).
        for (int n = 0; n < 11; n++) begin
            bus(VEC[n].iv, VEC[n].ia, VEC[n].dv, VEC[n].da, VEC[n].dd, wp, brk);
            chk($sformatf("R2/R3/R4/R5 vector %0d", n), 32'(wp), 32'(VEC[n].exp));
        end

        // R8: unused addresses leave settings untouched.
        cfg_write(4'd12, 32'hFFFF_FFFF);
        cfg_write(4'd15, 32'hFFFF_FFFF);
        bus(1'b1, 32'h100, 1'b1, 32'h1000, 32'hAA, wp, brk);
        chk("R8 unused write ignored", 32'(wp), 32'h1B);
        chk("R8 no breakpoint armed", 32'(brk), 32'h0);

        // R4: data-value enable for watchpoint 1.
        cfg_write(4'd9, 32'h3);
        bus(1'b0, 32'h0, 1'b1, 32'h3000, 32'h55, wp, brk);
        chk("R4 data gate blocks", 32'(wp), 32'h0);
        bus(1'b0, 32'h0, 1'b1, 32'h3000, 32'h56, wp, brk);
        chk("R4 data gate passes", 32'(wp), 32'h20);

        // R6: counter 0, count 3 on watchpoint 0.
        cfg_write(4'd10, (32'd0 << 16) | 32'd3);
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R6 event 1 no brk", 32'(brk), 32'h0);
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R6 event 2 no brk", 32'(brk), 32'h0);
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R6 event 3 brk", 32'(brk), 32'h1);
        @(negedge clk);
        chk("R6 brk one cycle", 32'(brk_req), 32'h0);

        // R7: stopped until reloaded.
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R7 no brk after firing", 32'(brk), 32'h0);
        cfg_write(4'd10, 32'd1);
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R7 reload fires", 32'(brk), 32'h1);
        cfg_write(4'd10, 32'd0);
        bus(1'b1, 32'h100, 1'b0, 32'h0, 32'h0, wp, brk);
        chk("R7 zero count disarmed", 32'(brk), 32'h0);

        // R9: counter 1 on watchpoint 4, count 2.
        cfg_write(4'd11, (32'd4 << 16) | 32'd2);
        bus(1'b0, 32'h0, 1'b1, 32'h1000, 32'hAA, wp, brk);
        chk("R9 counter1 event 1", 32'(brk), 32'h0);
        bus(1'b0, 32'h0, 1'b1, 32'h1000, 32'hAA, wp, brk);
        chk("R9 counter1 fires", 32'(brk), 32'h1);

        // R6: select 6 never counts.
        cfg_write(4'd10, (32'd6 << 16) | 32'd1);
        bus(1'b1, 32'h100, 1'b1, 32'h1000, 32'hAA, wp, brk);
        chk("R6 select 6 inert", 32'(brk), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule